// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is an N-bit (8 by default) storage and shift register. One parallel bus serves as both its load port and its output port. Tri-state pins are not modelled as such. The block presents the value it would drive (`bus_out`) and a single drive flag (`bus_oe`). The incoming value (`bus_in`) is whatever the resolved bus carries. A two-bit select picks one of four actions, which take effect on each rising clock edge: keep the contents, move every bit one place toward the top, move every bit one place toward bit 0, or capture the whole bus.

Each end of the register has a serial input and a serial output. The serial outputs always show the two end bits, so units can be chained. A unit's top serial output feeds the low serial input of the next unit, and the next unit's low serial output returns to the top serial input of the unit before it. Feeding the last unit's top output back into the first unit's low input makes the chained bits rotate. The bus is driven only when both active-low enables are low and the select is not the load code. An active-low clear empties the register at once, with no clock.

Top module: `ushift_bus_reg`

## Requirements
- R1: With sel = 2'b00, a rising clock edge leaves all bits unchanged.
- R2: With sel = 2'b01 (sel[0] high), a rising edge moves each bit i to bit i+1, `ser_lo_in` enters bit 0 and the old top bit is dropped.
- R3: With sel = 2'b10 (sel[1] high), a rising edge moves each bit i to bit i-1, `ser_hi_in` enters the top bit and the old bit 0 is dropped.
- R4: With sel = 2'b11, a rising edge copies `bus_in` into every bit, whatever the levels of `oe_a_n` and `oe_b_n`.
- R5: While sel = 2'b11, `bus_oe` is low.
- R6: While `oe_a_n` or `oe_b_n` is high, `bus_oe` is low.
- R7: While both enables are low and sel is not 2'b11, `bus_oe` is high. `bus_out` always carries the register contents, bit i on bus_out[i].
- R8: While `clr_n` is low, every bit is zero. This holds immediately, with no clock edge, and it takes precedence over sel and the clock.
- R9: `ser_lo_out` equals bit 0 and `ser_hi_out` equals the top bit at every moment, in every mode and for every enable level.
- R10: Two units joined through their serial pins behave as one 2N-bit register that shifts in both directions.
- R11: When the far unit's `ser_hi_out` is fed to the near unit's `ser_lo_in`, 2N upward shifts return the chained contents to their starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Action select: 00 keep, 01 up, 10 down, 11 load |
| ser_lo_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_hi_in | input | 1 | Serial bit entering the top bit on a downward shift |
| oe_a_n | input | 1 | First bus enable, active low |
| oe_b_n | input | 1 | Second bus enable, active low |
| bus_in | input | WIDTH | Resolved value of the shared bus |
| bus_out | output | WIDTH | Register contents offered to the bus |
| bus_oe | output | 1 | High when the block drives the bus |
| ser_lo_out | output | 1 | Current bit 0 |
| ser_hi_out | output | 1 | Current top bit |

## Verification
`bus_oe` is purely combinational from the select and enables, so it is due in the same cycle the inputs change. The bench samples it one time unit after driving inputs on the falling edge. The shift, hold and load results, and the serial outputs that follow them, are due one rising edge later. The reference model therefore updates only at the rising edge, and it is compared at the next falling-edge sample. The clear is checked two time units after `clr_n` falls, before any rising edge, which shows the clear needs no clock.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD = 2'b00,
      MODE_UP   = 2'b01,
      MODE_DOWN = 2'b10,
      MODE_LOAD = 2'b11
   } mode_e;
endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
   import ushift_pkg::*;
(
   input  logic [1:0] sel,
   output mode_e      mode,
   output logic       load_sel
);
   always_comb begin
      unique case (sel)
         2'b00:   mode = MODE_HOLD;
         2'b01:   mode = MODE_UP;
         2'b10:   mode = MODE_DOWN;
         default: mode = MODE_LOAD;
      endcase
   end

   assign load_sel = (mode == MODE_LOAD);
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
   import ushift_pkg::*;
(
   input  logic  clk,
   input  logic  clr_n,
   input  mode_e mode,
   input  logic  from_below,
   input  logic  from_above,
   input  logic  par_in,
   output logic  q
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         q <= 1'b0;
      end else begin
         unique case (mode)
            MODE_HOLD: q <= q;
            MODE_UP:   q <= from_below;
            MODE_DOWN: q <= from_above;
            MODE_LOAD: q <= par_in;
         endcase
      end
   end

   assert_hold_keeps_R1: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_HOLD) |=> $stable(q));
   assert_up_takes_below_R2: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_UP) |=> (q == $past(from_below)));
   assert_down_takes_above_R3: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_DOWN) |=> (q == $past(from_above)));
   assert_load_takes_bus_R4: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_LOAD) |=> (q == $past(par_in)));
   assert_clear_zero_R8: assert property (@(posedge clk)
      !clr_n |-> (q == 1'b0));
endmodule

// File: rtl/ushift_bus_drv.sv
module ushift_bus_drv #(
   parameter int WIDTH    = 8,
   parameter int OE_COUNT = 2
) (
   input  logic                load_sel,
   input  logic [OE_COUNT-1:0] oe_n,
   input  logic [WIDTH-1:0]    state,
   output logic [WIDTH-1:0]    bus_out,
   output logic                bus_oe
);
   if (OE_COUNT < 1) begin : g_bad_oe
      $error("ushift_bus_drv: OE_COUNT must be at least 1");
   end

   logic any_disable;
   assign any_disable = |oe_n;
   assign bus_oe      = !load_sel && !any_disable;
   assign bus_out     = state;
endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
   import ushift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       sel,
   input  logic             ser_lo_in,
   input  logic             ser_hi_in,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic             ser_lo_out,
   output logic             ser_hi_out
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ushift_bus_reg: WIDTH must be at least 2");
   end

   mode_e            mode;
   logic             load_sel;
   logic [WIDTH-1:0] state;

   ushift_mode_dec dec_i (
      .sel      (sel),
      .mode     (mode),
      .load_sel (load_sel)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic below_w;
      logic above_w;
      if (i == 0) begin : g_lo_end
         assign below_w = ser_lo_in;
      end else begin : g_lo_mid
         assign below_w = state[i-1];
      end
      if (i == TOP) begin : g_hi_end
         assign above_w = ser_hi_in;
      end else begin : g_hi_mid
         assign above_w = state[i+1];
      end
      ushift_cell cell_i (
         .clk        (clk),
         .clr_n      (clr_n),
         .mode       (mode),
         .from_below (below_w),
         .from_above (above_w),
         .par_in     (bus_in[i]),
         .q          (state[i])
      );
   end

   ushift_bus_drv #(.WIDTH(WIDTH), .OE_COUNT(2)) drv_i (
      .load_sel (load_sel),
      .oe_n     ({oe_b_n, oe_a_n}),
      .state    (state),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe)
   );

   assign ser_lo_out = state[0];
   assign ser_hi_out = state[TOP];

   assert_up_serial_entry_R2: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == 2'b01) |=> (ser_lo_out == $past(ser_lo_in)));
   assert_down_serial_entry_R3: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == 2'b10) |=> (ser_hi_out == $past(ser_hi_in)));
   assert_load_releases_bus_R5: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == 2'b11) |-> !bus_oe);
   assert_enable_releases_bus_R6: assert property (@(posedge clk) disable iff (!clr_n)
      (oe_a_n || oe_b_n) |-> !bus_oe);
   assert_bus_driven_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (!oe_a_n && !oe_b_n && sel != 2'b11) |-> bus_oe);
   assert_serial_ends_R9: assert property (@(posedge clk) disable iff (!clr_n)
      (sel == 2'b00) |=> $stable({ser_hi_out, ser_lo_out}));
endmodule

// File: tb/ushift_bus_reg_tb_top.sv
module ushift_bus_reg_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       clr_n = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       lo_in = 1'b0, hi_in = 1'b0;
   logic       oe_a_n = 1'b1, oe_b_n = 1'b1;
   logic [7:0] tb_data = 8'h00;
   logic       tb_drive = 1'b0;
   logic [7:0] bus_w, bus_out;
   logic       bus_oe, lo_out, hi_out;

   logic [1:0]  csel = 2'b00;
   logic        c_lo = 1'b0, c_hi = 1'b0, recirc = 1'b0;
   logic [15:0] c_data = 16'h0000;
   logic [7:0]  a_out, b_out;
   logic        a_oe, b_oe, a_lo_out, a_hi_out, b_lo_out, b_hi_out, a_lo_in;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0]  m = 8'h00;
   logic [15:0] cm = 16'h0000;
   string prev_tag = "R8";

   always #(CLK_PERIOD/2) clk = ~clk;

   assign bus_w = bus_oe ? bus_out : (tb_drive ? tb_data : 8'hzz);

   ushift_bus_reg dut_i (
      .clk(clk), .clr_n(clr_n), .sel(sel), .ser_lo_in(lo_in), .ser_hi_in(hi_in),
      .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bus_w), .bus_out(bus_out),
      .bus_oe(bus_oe), .ser_lo_out(lo_out), .ser_hi_out(hi_out));

   assign a_lo_in = recirc ? b_hi_out : c_lo;

   ushift_bus_reg chain_a (
      .clk(clk), .clr_n(clr_n), .sel(csel), .ser_lo_in(a_lo_in), .ser_hi_in(b_lo_out),
      .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(c_data[7:0]), .bus_out(a_out),
      .bus_oe(a_oe), .ser_lo_out(a_lo_out), .ser_hi_out(a_hi_out));

   ushift_bus_reg chain_b (
      .clk(clk), .clr_n(clr_n), .sel(csel), .ser_lo_in(a_hi_out), .ser_hi_in(c_hi),
      .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(c_data[15:8]), .bus_out(b_out),
      .bus_oe(b_oe), .ser_lo_out(b_lo_out), .ser_hi_out(b_hi_out));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called just after a falling edge with new inputs set.
   task automatic tick(input string tag);
      #1;
      check(prev_tag, {24'h0, bus_out}, {24'h0, m});
      check("R9", {30'h0, hi_out, lo_out}, {30'h0, m[7], m[0]});
      check(sel == 2'b11 ? "R5" : ((oe_a_n || oe_b_n) ? "R6" : "R7"),
            {31'h0, bus_oe}, {31'h0, (sel != 2'b11) && !oe_a_n && !oe_b_n});
      check("R5", {31'h0, bus_oe && tb_drive}, 32'h0);
      check(recirc ? "R11" : "R10", {16'h0, b_out, a_out}, {16'h0, cm});
      @(posedge clk);
      unique case (sel)
         2'b01:   m = {m[6:0], lo_in};
         2'b10:   m = {hi_in, m[7:1]};
         2'b11:   m = bus_w;
         default: m = m;
      endcase
      unique case (csel)
         2'b01:   cm = {cm[14:0], recirc ? cm[15] : c_lo};
         2'b10:   cm = {c_hi, cm[15:1]};
         2'b11:   cm = c_data;
         default: cm = cm;
      endcase
      prev_tag = tag;
      @(negedge clk);
   endtask

   function automatic string tag_of(input logic [1:0] s);
      return (s == 2'b00) ? "R1" : (s == 2'b01) ? "R2" : (s == 2'b10) ? "R3" : "R4";
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // Reset state (R8)
      check("R8", {16'h0, b_out, a_out}, 32'h0);
      check("R8", {24'h0, bus_out}, 32'h0);
      clr_n = 1'b1;
      @(negedge clk);

      // Load with both enables active: still loads, bus released (R4, R5)
      sel = 2'b11; oe_a_n = 1'b0; oe_b_n = 1'b0; tb_drive = 1'b1; tb_data = 8'hA5;
      tick("R4");
      tb_drive = 1'b0;

      // Hold under each enable combination (R1, R6, R7)
      for (int k = 0; k < 4; k++) begin
         sel = 2'b00; oe_a_n = k[0]; oe_b_n = k[1];
         tick("R1");
      end

      // Upward shifts with a serial pattern (R2)
      oe_a_n = 1'b0; oe_b_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
         sel = 2'b01; lo_in = (k % 3 == 0);
         tick("R2");
      end
      // Downward shifts (R3)
      oe_b_n = 1'b0;
      for (int k = 0; k < 10; k++) begin
         sel = 2'b10; hi_in = (k % 2 == 1);
         tick("R3");
      end
      // Mixed modes with reloads (R1-style hold included)
      for (int k = 0; k < 24; k++) begin
         sel = 2'((k * 7 + 1) % 4);
         lo_in = k[1]; hi_in = k[2]; oe_a_n = k[3]; oe_b_n = 1'b0;
         tb_data = 8'((k * 37) ^ 8'h5C);
         tb_drive = (sel == 2'b11);
         tick(tag_of(sel));
      end
      tb_drive = 1'b0;

      // Asynchronous clear between edges (R8)
      sel = 2'b11; tb_drive = 1'b1; tb_data = 8'hFF;
      csel = 2'b11; c_data = 16'hFFFF;
      tick("R4");
      sel = 2'b00; tb_drive = 1'b0; csel = 2'b00;
      #2 clr_n = 1'b0;
      #2;
      check("R8", {24'h0, bus_out}, 32'h0);
      check("R8", {30'h0, hi_out, lo_out}, 32'h0);
      check("R8", {16'h0, b_out, a_out}, 32'h0);
      m = 8'h00; cm = 16'h0000; prev_tag = "R8";
      @(posedge clk); sel = 2'b11; tb_drive = 1'b1;
      @(negedge clk);
      check("R8", {24'h0, bus_out}, 32'h0);
      clr_n = 1'b1; sel = 2'b00; tb_drive = 1'b0;

      // Chain: load then shift up with serial input (R10)
      csel = 2'b11; c_data = 16'h8001;
      tick("R10");
      for (int k = 0; k < 20; k++) begin
         csel = 2'b01; c_lo = (k % 4 == 1);
         tick("R10");
      end
      for (int k = 0; k < 20; k++) begin
         csel = 2'b10; c_hi = (k % 3 == 2);
         tick("R10");
      end
      // Recirculating loop over 16 bits (R11)
      csel = 2'b11; c_data = 16'hC35A;
      tick("R11");
      recirc = 1'b1;
      for (int k = 0; k < 16; k++) begin
         csel = 2'b01;
         tick("R11");
      end
      csel = 2'b00;
      #1 check("R11", {16'h0, b_out, a_out}, 32'h0000C35A);
      tick("R11");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule